// File: doc/BRIEF.md
# Quadrature Encoder Counter with Selectable Active Edge

This block counts events on two external inputs, channel A and channel B, inside a synchronous clock domain. Both inputs are brought in through two-flop synchronisers and a previous-value register, so each change is seen as a single-cycle edge event. In simple mode only channel A matters: every active edge of A adds one to the count. In encoder mode A and B are treated as a quadrature pair. The count moves up or down depending on which input moved, in which direction it moved, and the level of the other input.

Software drives a small write port with four addresses. One enables counting, one selects the mode and the active edge, one sets a wrap ceiling, and one clears status flags. The count is always visible on an output bus. Two sticky status flags report that the ceiling and a zero compare value were loaded when counting was switched on. Mode, edge and ceiling can only be changed while counting is off.

Top module: `qenc_counter`

## Requirements
- R1: After reset the count is 0, both status flags are 0, counting is disabled, the mode is simple with rising edges, and the ceiling holds the all-ones value (16'hFFFF).
- R2: In simple mode the count increases by one on each active edge of channel A and channel B is ignored; the count changes on the third rising clock edge after an input change.
- R3: The config register (address 1) holds the encoder-mode flag in bit 0 and the edge select in bits 2:1: 00 means rising only, 01 means falling only, 10 or 11 means both edges.
- R4: In encoder mode with rising edges, an A rise counts down if B is high and up if B is low, and a B rise counts up if A is high and down if A is low; falling edges do nothing.
- R5: In encoder mode with falling edges, an A fall counts up if B is high and down if B is low, and a B fall counts down if A is high and up if A is low; rising edges do nothing.
- R6: In encoder mode with both edges, the R4 and R5 rules both apply, so one full quadrature cycle moves the count by four.
- R7: Counting up from a value at or above the ceiling gives 0, and counting down from 0 gives the ceiling.
- R8: A ceiling write (address 2) with bit 16 of the write data set is rejected, and the ceiling keeps its previous value.
- R9: Writes to the config register and to the ceiling register are ignored while counting is enabled.
- R10: Writing 1 to bit 0 of address 0 while disabled enables counting and sets both the ceiling-loaded flag and the compare-loaded flag. A write to address 3 clears the ceiling-loaded flag when bit 0 is 1 and the compare-loaded flag when bit 1 is 1.
- R11: While counting is disabled the count holds its value, and input changes made while disabled produce no count after re-enable.
- R12: In encoder mode, a cycle in which both synchronised inputs change together leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_a | input | 1 | Channel A, asynchronous |
| in_b | input | 1 | Channel B, asynchronous |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 config, 2 ceiling, 3 flag clear |
| reg_wdata | input | 17 | Write data; bit 16 flags an out-of-range ceiling |
| count | output | 16 | Current count |
| stat_ceil_ok | output | 1 | Sticky flag: ceiling loaded on enable |
| stat_cmp_ok | output | 1 | Sticky flag: compare value loaded on enable |

## Verification
A table drives channel-level sequences through every mode and edge setting. Single-channel toggles in simple mode confirm that B is ignored and that rising, falling and both edges are told apart. Forward and reverse quadrature walks under each encoder edge setting separate the four rows of the direction table. Rising and falling steps are paired so that a wrong edge filter shows up as a count that should not be there. Both channels are also flipped together to show that the simultaneous change is dropped. Directed steps then force wraps against the default ceiling and against a programmed one. These steps also attempt an oversize ceiling write and writes made while enabled, and they show that the count holds while disabled.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

  typedef enum logic [1:0] {
    EDGE_RISE  = 2'b00,
    EDGE_FALL  = 2'b01,
    EDGE_BOTH  = 2'b10,
    EDGE_BOTHX = 2'b11
  } edge_sel_e;

  typedef struct packed {
    edge_sel_e esel;
    logic      enc;
  } cfg_t;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_CFG  = 2'd1;
  localparam logic [1:0] ADDR_CEIL = 2'd2;
  localparam logic [1:0] ADDR_CLR  = 2'd3;

endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);

  for (genvar g = 0; g < W; g++) begin : g_ch
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        meta_q <= raw[g];
        sync_q <= meta_q;
        prev_q <= sync_q;
      end
    end

    assign cur[g]  = sync_q;
    assign prev[g] = prev_q;
  end

endmodule

// File: rtl/qenc_decode.sv
module qenc_decode
  import qenc_pkg::*;
(
  input  logic [1:0] cur,
  input  logic [1:0] prev,
  input  cfg_t       cfg,
  output logic       step_up,
  output logic       step_dn
);

  logic [1:0] rise, fall, chg;
  logic       use_r, use_f;

  assign rise  = cur & ~prev;
  assign fall  = ~cur & prev;
  assign chg   = cur ^ prev;
  assign use_r = (cfg.esel != EDGE_FALL);
  assign use_f = (cfg.esel != EDGE_RISE);

  always_comb begin
    step_up = 1'b0;
    step_dn = 1'b0;
    if (!cfg.enc) begin
      step_up = (rise[0] & use_r) | (fall[0] & use_f);
    end else if (chg == 2'b01) begin
      if (rise[0] && use_r) begin
        step_up = ~cur[1];
        step_dn =  cur[1];
      end else if (fall[0] && use_f) begin
        step_up =  cur[1];
        step_dn = ~cur[1];
      end
    end else if (chg == 2'b10) begin
      if (rise[1] && use_r) begin
        step_up =  cur[0];
        step_dn = ~cur[0];
      end else if (fall[1] && use_f) begin
        step_up = ~cur[0];
        step_dn =  cur[0];
      end
    end
  end

endmodule

// File: rtl/qenc_regs.sv
module qenc_regs
  import qenc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [CNT_W:0]   reg_wdata,
  output logic             en_q,
  output cfg_t             cfg_q,
  output logic [CNT_W-1:0] ceil_q,
  output logic             flag_ceil_q,
  output logic             flag_cmp_q
);

  logic             en_d, flag_ceil_d, flag_cmp_d;
  cfg_t             cfg_d;
  logic [CNT_W-1:0] ceil_d;

  always_comb begin
    en_d        = en_q;
    cfg_d       = cfg_q;
    ceil_d      = ceil_q;
    flag_ceil_d = flag_ceil_q;
    flag_cmp_d  = flag_cmp_q;
    if (reg_we) begin
      case (reg_addr)
        ADDR_CTRL: begin
          en_d = reg_wdata[0];
          if (reg_wdata[0] && !en_q) begin
            flag_ceil_d = 1'b1;
            flag_cmp_d  = 1'b1;
          end
        end
        ADDR_CFG: begin
          if (!en_q) cfg_d = cfg_t'(reg_wdata[2:0]);
        end
        ADDR_CEIL: begin
          if (!en_q && !reg_wdata[CNT_W]) ceil_d = reg_wdata[CNT_W-1:0];
        end
        default: begin
          if (reg_wdata[0]) flag_ceil_d = 1'b0;
          if (reg_wdata[1]) flag_cmp_d  = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q        <= 1'b0;
      cfg_q       <= '{esel: EDGE_RISE, enc: 1'b0};
      ceil_q      <= '1;
      flag_ceil_q <= 1'b0;
      flag_cmp_q  <= 1'b0;
    end else begin
      en_q        <= en_d;
      cfg_q       <= cfg_d;
      ceil_q      <= ceil_d;
      flag_ceil_q <= flag_ceil_d;
      flag_cmp_q  <= flag_cmp_d;
    end
  end

endmodule

// File: rtl/qenc_counter.sv
module qenc_counter
  import qenc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_a,
  input  logic             in_b,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [CNT_W:0]   reg_wdata,
  output logic [CNT_W-1:0] count,
  output logic             stat_ceil_ok,
  output logic             stat_cmp_ok
);

  localparam int CH = 2;

  logic [CH-1:0]    sync_cur, sync_prev;
  logic             step_up, step_dn, en_q;
  cfg_t             cfg_q;
  logic [CNT_W-1:0] ceil_q, cnt_q, cnt_d;

  qenc_sync #(.W(CH)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .raw  ({in_b, in_a}),
    .cur  (sync_cur),
    .prev (sync_prev)
  );

  qenc_decode u_dec (
    .cur    (sync_cur),
    .prev   (sync_prev),
    .cfg    (cfg_q),
    .step_up(step_up),
    .step_dn(step_dn)
  );

  qenc_regs #(.CNT_W(CNT_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .en_q       (en_q),
    .cfg_q      (cfg_q),
    .ceil_q     (ceil_q),
    .flag_ceil_q(stat_ceil_ok),
    .flag_cmp_q (stat_cmp_ok)
  );

  always_comb begin
    cnt_d = cnt_q;
    if (step_up) begin
      cnt_d = (cnt_q >= ceil_q) ? '0 : cnt_q + 1'b1;
    end else if (step_dn) begin
      cnt_d = (cnt_q == '0) ? ceil_q : cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (en_q) begin
      cnt_q <= cnt_d;
    end
  end

  assign count = cnt_q;

endmodule

// File: rtl/qenc_checker.sv
module qenc_checker
  import qenc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_we,
  input logic [1:0]       reg_addr,
  input logic [CNT_W:0]   reg_wdata,
  input logic             en_q,
  input cfg_t             cfg_q,
  input logic [CNT_W-1:0] ceil_q,
  input logic [1:0]       sync_cur,
  input logic [1:0]       sync_prev,
  input logic [CNT_W-1:0] count,
  input logic             stat_ceil_ok,
  input logic             stat_cmp_ok
);

  // R11
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> $stable(count));

  // R8
  big_ceil_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == ADDR_CEIL && reg_wdata[CNT_W]) |=> $stable(ceil_q));

  // R9
  cfg_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == ADDR_CFG && en_q) |=> $stable(cfg_q));

  // R9
  ceil_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == ADDR_CEIL && en_q) |=> $stable(ceil_q));

  // R2
  simple_up_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !cfg_q.enc) |=>
      (count == $past(count) || count == $past(count) + 1'b1 || count == '0));

  // R10
  enable_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == ADDR_CTRL && reg_wdata[0] && !en_q) |=>
      (en_q && stat_ceil_ok && stat_cmp_ok));

  // R12
  dual_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && cfg_q.enc && (sync_cur ^ sync_prev) == 2'b11) |=> $stable(count));

endmodule

bind qenc_counter qenc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_we      (reg_we),
  .reg_addr    (reg_addr),
  .reg_wdata   (reg_wdata),
  .en_q        (en_q),
  .cfg_q       (cfg_q),
  .ceil_q      (ceil_q),
  .sync_cur    (sync_cur),
  .sync_prev   (sync_prev),
  .count       (count),
  .stat_ceil_ok(stat_ceil_ok),
  .stat_cmp_ok (stat_cmp_ok)
);

// File: tb/sim_qenc_counter.sv
module sim_qenc_counter;

  localparam int CNT_W = 16;

  logic             clk, rst_n, in_a, in_b, reg_we;
  logic [1:0]       reg_addr;
  logic [CNT_W:0]   reg_wdata;
  logic [CNT_W-1:0] count;
  logic             stat_ceil_ok, stat_cmp_ok;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  qenc_counter #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .in_a(in_a), .in_b(in_b),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .count(count), .stat_ceil_ok(stat_ceil_ok), .stat_cmp_ok(stat_cmp_ok)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic [2:0]  cfg;   // {edge[1:0], enc}
    logic        a;
    logic        b;
    logic [15:0] exp;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t VEC [0:NV-1] = '{
    // simple, rising (R2, R3)
    '{3'b000, 1'b1, 1'b0, 16'd1},
    '{3'b000, 1'b0, 1'b0, 16'd1},
    '{3'b000, 1'b0, 1'b1, 16'd1},
    '{3'b000, 1'b1, 1'b1, 16'd2},
    '{3'b000, 1'b0, 1'b0, 16'd2},
    // simple, falling
    '{3'b010, 1'b1, 1'b0, 16'd2},
    '{3'b010, 1'b0, 1'b0, 16'd3},
    // simple, both
    '{3'b100, 1'b1, 1'b0, 16'd4},
    '{3'b100, 1'b0, 1'b0, 16'd5},
    // encoder, rising (R4)
    '{3'b001, 1'b1, 1'b0, 16'd6},
    '{3'b001, 1'b1, 1'b1, 16'd7},
    '{3'b001, 1'b0, 1'b1, 16'd7},
    '{3'b001, 1'b0, 1'b0, 16'd7},
    '{3'b001, 1'b0, 1'b1, 16'd6},
    '{3'b001, 1'b1, 1'b1, 16'd5},
    // encoder, falling (R5)
    '{3'b011, 1'b0, 1'b1, 16'd6},
    '{3'b011, 1'b0, 1'b0, 16'd7},
    '{3'b011, 1'b1, 1'b0, 16'd7},
    '{3'b011, 1'b1, 1'b1, 16'd7},
    '{3'b011, 1'b1, 1'b0, 16'd6},
    '{3'b011, 1'b0, 1'b0, 16'd5},
    // encoder, both (R6), then simultaneous change (R12)
    '{3'b101, 1'b1, 1'b0, 16'd6},
    '{3'b101, 1'b1, 1'b1, 16'd7},
    '{3'b101, 1'b0, 1'b1, 16'd8},
    '{3'b101, 1'b0, 1'b0, 16'd9},
    '{3'b101, 1'b1, 1'b1, 16'd9},
    '{3'b101, 1'b0, 1'b0, 16'd9},
    '{3'b101, 1'b0, 1'b1, 16'd8},
    '{3'b101, 1'b1, 1'b1, 16'd7}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] addr, input logic [CNT_W:0] data);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = addr; reg_wdata = data;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic drive(input logic a, input logic b);
    @(negedge clk);
    in_a = a; in_b = b;
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic string vec_req(input logic [2:0] c);
    if (!c[0]) return "R2/R3 simple";
    case (c[2:1])
      2'b00:   return "R4 enc-rise";
      2'b01:   return "R5 enc-fall";
      default: return "R6/R12 enc-both";
    endcase
  endfunction

  initial begin
    logic [2:0] cur_cfg;
    rst_n = 1'b0; in_a = 1'b0; in_b = 1'b0;
    reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 count", 32'(count), 32'd0);
    check("R1 ceil flag", 32'(stat_ceil_ok), 32'd0);
    check("R1 cmp flag", 32'(stat_cmp_ok), 32'd0);
    // R1: reset mode is simple rising; enable without config write
    wr(2'd0, 17'd1);
    cur_cfg = 3'b000;

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].cfg != cur_cfg) begin
        wr(2'd0, 17'd0);
        wr(2'd1, {14'd0, VEC[i].cfg});
        wr(2'd0, 17'd1);
        cur_cfg = VEC[i].cfg;
      end
      drive(VEC[i].a, VEC[i].b);
      check(vec_req(VEC[i].cfg), 32'(count), 32'(VEC[i].exp));
    end

    // Directed: fresh reset
    @(negedge clk);
    rst_n = 1'b0; in_a = 1'b0; in_b = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 count after reset", 32'(count), 32'd0);
    wr(2'd1, 17'b101);
    wr(2'd0, 17'd1);
    check("R10 ceil flag set", 32'(stat_ceil_ok), 32'd1);
    check("R10 cmp flag set", 32'(stat_cmp_ok), 32'd1);
    // R7/R1: down from 0 wraps to reset ceiling FFFF
    drive(1'b0, 1'b1);
    check("R7 down wrap to default ceiling", 32'(count), 32'hFFFF);
    // R7: up from FFFF wraps to 0
    drive(1'b0, 1'b0);
    check("R7 up wrap at ceiling", 32'(count), 32'd0);
    // R10: flag clears
    wr(2'd3, 17'b01);
    check("R10 ceil flag cleared", 32'(stat_ceil_ok), 32'd0);
    check("R10 cmp flag kept", 32'(stat_cmp_ok), 32'd1);
    wr(2'd3, 17'b10);
    check("R10 cmp flag cleared", 32'(stat_cmp_ok), 32'd0);
    // R8: program ceiling 5, then attempt an out-of-range write
    wr(2'd0, 17'd0);
    wr(2'd2, 17'd5);
    wr(2'd2, 17'h10000);
    wr(2'd0, 17'd1);
    drive(1'b0, 1'b1);
    check("R8 oversize ceiling rejected, down wrap", 32'(count), 32'd5);
    // R9: writes while enabled are ignored
    wr(2'd2, 17'd3);
    wr(2'd1, 17'b000);
    drive(1'b1, 1'b1);
    check("R9 config write refused", 32'(count), 32'd4);
    drive(1'b0, 1'b1);
    check("R9 ceiling write refused", 32'(count), 32'd5);
    drive(1'b0, 1'b0);
    check("R7 up wrap at programmed ceiling", 32'(count), 32'd0);
    // R11: disabled holds count, no catch-up after enable
    wr(2'd0, 17'd0);
    drive(1'b1, 1'b0);
    drive(1'b1, 1'b1);
    check("R11 hold while disabled", 32'(count), 32'd0);
    wr(2'd0, 17'd1);
    repeat (4) @(negedge clk);
    check("R11 no count on re-enable", 32'(count), 32'd0);
    drive(1'b0, 1'b1);
    check("R11 counts again after enable", 32'(count), 32'd1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule